// File: doc/BRIEF.md
# Variable-Length Instruction Stream Decoder

This block sits between a byte-wide code fetch path and an execution or trace stage. It accepts machine code for an accumulator-style instruction set with 8-bit opcodes, one byte per valid/ready transfer. It finds the addressing mode of each opcode and collects however many trailing bytes that mode needs. It then presents one decoded record per instruction. The record holds the opcode, the mode, the index register, the size attribute, an operand of up to 32 bits, the total byte count and an invalid flag.

Instruction length is not fixed by the opcode alone. Immediate instructions carry an attribute byte, and its low two bits choose a 1-, 2- or 4-byte literal. Absolute and indirect instructions also carry an attribute byte, followed by a 4-byte address. Relative branches carry a signed 16-bit offset and no attribute. The block flags unassigned opcodes and immediate attributes whose size code is 3. While a finished record waits to be taken, the byte input is stalled.

Top module: `insn_stream_decoder`

## Requirements
- R1: An implied-mode opcode produces a record of length 1 with operand 0, mode 0 and index 0.
- R2: The mode field uses bit 0 for relative, bit 1 for immediate, bit 2 for indirect and bit 3 for absolute. The index field is 01 for X, 10 for Y and 00 for none. The decoder assigns both from the opcode grid: in column 0, odd rows are relative; 0x00/0x40/0x60 are implied, 0x20 is absolute and 0xA0/0xC0/0xE0 are immediate. Column 1 is indirect, indexed by X for 0x01/0x41/0x61/0x81/0xA1/0xC1/0xE1 and by Y otherwise. 0xA2 is immediate. Column 8 is implied. Column 9 is immediate on even rows except 0x89, and absolute,Y on odd rows. Column A is implied on rows 0,2,4,6,8,9,A,B,C,E. Column C is absolute on rows 2,4,8,A,C,E, indirect at 0x6C and absolute,X at 0xBC. Column D is absolute, indexed by X on odd rows. Column E is absolute on even rows, absolute,Y at 0xBE, unassigned at 0x9E and absolute,X on the other odd rows. Every other opcode is unassigned.
- R3: A relative opcode takes two more bytes, least significant first. The output operand is that 16-bit value sign-extended to 32 bits, and the length is 3.
- R4: An immediate opcode takes an attribute byte whose bits [1:0] select 1, 2 or 4 literal bytes for codes 0, 1 and 2. The literal is assembled little-endian and zero-extended. The length is 3, 4 or 6, and the size field reports the attribute's bits [1:0].
- R5: An immediate attribute with bits [1:0] = 3 yields an invalid record of length 2 with size 3 and operand 0. No literal byte is consumed, so the next byte is taken as an opcode.
- R6: An unassigned opcode yields an invalid record of length 1 with mode 0 and index 0, and the next byte is taken as an opcode.
- R7: An absolute or indirect opcode takes an attribute byte and then four address bytes, little-endian. The length is 6, the size field reports the attribute's bits [1:0], and the record is never invalid.
- R8: While a record is offered and not accepted, it stays unchanged and in_ready is low. Records leave in input order.
- R9: A synchronous reset clears any partial instruction. Afterwards out_valid is low, in_ready is high and the next byte is decoded as an opcode.
- R10: At most one bit of the mode field is set in any offered record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A code byte is offered |
| in_ready | output | 1 | Decoder can take a code byte |
| in_byte | input | 8 | Code byte |
| out_valid | output | 1 | A decoded record is offered |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 8 | Opcode byte of the instruction |
| out_mode | output | 4 | Mode bits: 0 relative, 1 immediate, 2 indirect, 3 absolute |
| out_index | output | 2 | Index register: 01 X, 10 Y, 00 none |
| out_size | output | 2 | Attribute bits [1:0], 0 when no attribute byte |
| out_operand | output | 32 | Assembled literal, offset or address |
| out_len | output | 3 | Bytes consumed by the instruction |
| out_invalid | output | 1 | Unassigned opcode or bad immediate size |

## Verification
The assertions watch record shape on every cycle. They check that the length matches the mode and size, that relative offsets are sign-extended, that invalid records have one of the two legal forms, that the mode is one-hot, that a refused record holds still with input stalled, and that reset idles the block. Whether the mode and index match the opcode grid, whether bytes land in the right operand lanes, and whether the stream resynchronises after a bad attribute or a reset in mid-instruction can only be shown by the bench. It runs every opcode and the directed cases through a behavioural model, with irregular gaps on both handshakes.

// File: rtl/isd_pkg.sv
package isd_pkg;
    localparam int OPND_BYTES = 4;
    localparam int ADDR_BYTES = 4;
    localparam int REL_BYTES  = 2;
    localparam int OPND_W     = 8 * OPND_BYTES;
    localparam int LEN_W      = $clog2(ADDR_BYTES + 3);
    localparam int CNT_W      = $clog2(OPND_BYTES + 1);
    localparam int LANE_W     = $clog2(OPND_BYTES);

    localparam logic [3:0] MODE_NONE = 4'b0000;
    localparam logic [3:0] MODE_REL  = 4'b0001;
    localparam logic [3:0] MODE_IMM  = 4'b0010;
    localparam logic [3:0] MODE_IND  = 4'b0100;
    localparam logic [3:0] MODE_ABS  = 4'b1000;

    localparam logic [1:0] IDX_NONE = 2'b00;
    localparam logic [1:0] IDX_X    = 2'b01;
    localparam logic [1:0] IDX_Y    = 2'b10;
    localparam logic [1:0] SIZE_BAD = 2'b11;

    typedef enum logic [1:0] {ST_OPC, ST_ATTR, ST_DATA, ST_EMIT} isd_state_e;

    typedef struct packed {
        logic       assigned;
        logic [3:0] mode;
        logic [1:0] idx;
    } isd_class_t;

    typedef struct packed {
        logic [7:0]        opcode;
        logic [3:0]        mode;
        logic [1:0]        idx;
        logic [1:0]        size;
        logic [OPND_W-1:0] operand;
        logic [LEN_W-1:0]  len;
        logic              invalid;
    } isd_rec_t;

    typedef struct packed {
        isd_state_e        st;
        isd_rec_t          rec;
        logic [CNT_W-1:0]  left;
        logic [LANE_W-1:0] lane;
        logic              rel;
    } isd_regs_t;
endpackage

// File: rtl/isd_mode_lookup.sv
module isd_mode_lookup
    import isd_pkg::*;
(
    input  logic [7:0] opcode,
    output isd_class_t cls
);
    logic [3:0] row;
    logic       odd;

    assign row = opcode[7:4];
    assign odd = opcode[4];

    always_comb begin
        cls = '{assigned: 1'b1, mode: MODE_NONE, idx: IDX_NONE};
        case (opcode[3:0])
            4'h0: begin
                if (odd) cls.mode = MODE_REL;
                else begin
                    case (row)
                        4'h0, 4'h4, 4'h6: cls.mode = MODE_NONE;
                        4'h2:             cls.mode = MODE_ABS;
                        4'hA, 4'hC, 4'hE: cls.mode = MODE_IMM;
                        default:          cls.assigned = 1'b0;
                    endcase
                end
            end
            4'h1: begin
                cls.mode = MODE_IND;
                cls.idx  = (odd || row == 4'h2) ? IDX_Y : IDX_X;
            end
            4'h2: begin
                if (row == 4'hA) cls.mode = MODE_IMM;
                else             cls.assigned = 1'b0;
            end
            4'h8: cls.mode = MODE_NONE;
            4'h9: begin
                if (odd) begin
                    cls.mode = MODE_ABS;
                    cls.idx  = IDX_Y;
                end else if (row == 4'h8) cls.assigned = 1'b0;
                else                      cls.mode = MODE_IMM;
            end
            4'hA: begin
                case (row)
                    4'h1, 4'h3, 4'h5, 4'h7, 4'hD, 4'hF: cls.assigned = 1'b0;
                    default:                            cls.mode = MODE_NONE;
                endcase
            end
            4'hC: begin
                case (row)
                    4'h2, 4'h4, 4'h8, 4'hA, 4'hC, 4'hE: cls.mode = MODE_ABS;
                    4'h6: cls.mode = MODE_IND;
                    4'hB: begin
                        cls.mode = MODE_ABS;
                        cls.idx  = IDX_X;
                    end
                    default: cls.assigned = 1'b0;
                endcase
            end
            4'hD: begin
                cls.mode = MODE_ABS;
                cls.idx  = odd ? IDX_X : IDX_NONE;
            end
            4'hE: begin
                cls.mode = MODE_ABS;
                if (odd) begin
                    case (row)
                        4'h9:    cls.assigned = 1'b0;
                        4'hB:    cls.idx = IDX_Y;
                        default: cls.idx = IDX_X;
                    endcase
                end
            end
            default: cls.assigned = 1'b0;
        endcase
        if (!cls.assigned) begin
            cls.mode = MODE_NONE;
            cls.idx  = IDX_NONE;
        end
    end
endmodule

// File: rtl/isd_attr_len.sv
module isd_attr_len
    import isd_pkg::*;
(
    input  logic             is_imm,
    input  logic [1:0]       size,
    output logic [CNT_W-1:0] count,
    output logic             bad
);
    always_comb begin
        bad   = 1'b0;
        count = CNT_W'(ADDR_BYTES);
        if (is_imm) begin
            case (size)
                2'd0:    count = CNT_W'(1);
                2'd1:    count = CNT_W'(2);
                2'd2:    count = CNT_W'(OPND_BYTES);
                default: begin
                    count = '0;
                    bad   = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/insn_stream_decoder.sv
module insn_stream_decoder
    import isd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_byte,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_opcode,
    output logic [3:0]        out_mode,
    output logic [1:0]        out_index,
    output logic [1:0]        out_size,
    output logic [OPND_W-1:0] out_operand,
    output logic [LEN_W-1:0]  out_len,
    output logic              out_invalid
);
    isd_regs_t         q, d;
    isd_class_t        cls;
    logic [CNT_W-1:0]  attr_cnt;
    logic              attr_bad;
    logic              take;
    logic [OPND_W-1:0] merged;

    isd_mode_lookup u_lookup (
        .opcode (in_byte),
        .cls    (cls)
    );

    isd_attr_len u_attr (
        .is_imm (q.rec.mode == MODE_IMM),
        .size   (in_byte[1:0]),
        .count  (attr_cnt),
        .bad    (attr_bad)
    );

    // each operand lane takes the incoming byte when the lane pointer selects it
    for (genvar k = 0; k < OPND_BYTES; k++) begin : g_lane
        assign merged[8*k +: 8] = (q.lane == LANE_W'(k)) ? in_byte : q.rec.operand[8*k +: 8];
    end

    assign in_ready = (q.st != ST_EMIT);
    assign take     = in_valid && in_ready;

    always_comb begin
        d = q;
        case (q.st)
            ST_OPC: begin
                if (take) begin
                    d.rec        = '0;
                    d.rec.opcode = in_byte;
                    d.rec.len    = LEN_W'(1);
                    d.lane       = '0;
                    d.left       = '0;
                    d.rel        = 1'b0;
                    if (!cls.assigned) begin
                        d.rec.invalid = 1'b1;
                        d.st          = ST_EMIT;
                    end else begin
                        d.rec.mode = cls.mode;
                        d.rec.idx  = cls.idx;
                        if (cls.mode == MODE_NONE) begin
                            d.st = ST_EMIT;
                        end else if (cls.mode == MODE_REL) begin
                            d.rel  = 1'b1;
                            d.left = CNT_W'(REL_BYTES);
                            d.st   = ST_DATA;
                        end else begin
                            d.st = ST_ATTR;
                        end
                    end
                end
            end
            ST_ATTR: begin
                if (take) begin
                    d.rec.len  = q.rec.len + LEN_W'(1);
                    d.rec.size = in_byte[1:0];
                    if (attr_bad) begin
                        d.rec.invalid = 1'b1;
                        d.st          = ST_EMIT;
                    end else begin
                        d.left = attr_cnt;
                        d.st   = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (take) begin
                    d.rec.len     = q.rec.len + LEN_W'(1);
                    d.rec.operand = merged;
                    d.lane        = q.lane + LANE_W'(1);
                    d.left        = q.left - CNT_W'(1);
                    if (q.left == CNT_W'(1)) begin
                        d.st = ST_EMIT;
                        if (q.rel)
                            d.rec.operand[OPND_W-1:8*REL_BYTES] = {(OPND_W-8*REL_BYTES){in_byte[7]}};
                    end
                end
            end
            ST_EMIT: begin
                if (out_ready) d.st = ST_OPC;
            end
            default: d.st = ST_OPC;
        endcase
        if (rst) d = '0;
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign out_valid   = (q.st == ST_EMIT);
    assign out_opcode  = q.rec.opcode;
    assign out_mode    = q.rec.mode;
    assign out_index   = q.rec.idx;
    assign out_size    = q.rec.size;
    assign out_operand = q.rec.operand;
    assign out_len     = q.rec.len;
    assign out_invalid = q.rec.invalid;
endmodule

// File: rtl/isd_checker.sv
module isd_checker
    import isd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_opcode,
    input logic [3:0]        out_mode,
    input logic [1:0]        out_index,
    input logic [1:0]        out_size,
    input logic [OPND_W-1:0] out_operand,
    input logic [LEN_W-1:0]  out_len,
    input logic              out_invalid
);
    a_r8_stall_input: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    a_r8_hold_record: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_opcode) && $stable(out_mode)
            && $stable(out_index) && $stable(out_size) && $stable(out_operand)
            && $stable(out_len) && $stable(out_invalid));

    a_r9_reset_idle: assert property (@(posedge clk)
        rst |=> !out_valid && in_ready);

    a_r10_mode_onehot: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot0(out_mode));

    a_r1_implied_shape: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_invalid && out_mode == MODE_NONE |->
            out_len == LEN_W'(1) && out_operand == '0 && out_index == IDX_NONE);

    a_r3_rel_shape: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_mode == MODE_REL |->
            out_len == LEN_W'(1 + REL_BYTES)
            && out_operand[OPND_W-1:8*REL_BYTES] == {(OPND_W-8*REL_BYTES){out_operand[8*REL_BYTES-1]}});

    a_r4_imm_len: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_mode == MODE_IMM && !out_invalid |->
            out_size != SIZE_BAD && out_len == LEN_W'(2) + (LEN_W'(1) << out_size));

    a_r5_bad_attr: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_invalid && out_mode == MODE_IMM |->
            out_size == SIZE_BAD && out_len == LEN_W'(2) && out_operand == '0);

    a_r6_unassigned: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_invalid && out_mode != MODE_IMM |->
            out_len == LEN_W'(1) && out_mode == MODE_NONE && out_index == IDX_NONE);

    a_r7_addr_len: assert property (@(posedge clk) disable iff (rst)
        out_valid && (out_mode == MODE_ABS || out_mode == MODE_IND) |->
            out_len == LEN_W'(ADDR_BYTES + 2) && !out_invalid);
endmodule

bind insn_stream_decoder isd_checker u_isd_checker (
    .clk         (clk),
    .rst         (rst),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_opcode  (out_opcode),
    .out_mode    (out_mode),
    .out_index   (out_index),
    .out_size    (out_size),
    .out_operand (out_operand),
    .out_len     (out_len),
    .out_invalid (out_invalid)
);

// File: tb/insn_stream_decoder_test.sv
`timescale 1ns/1ps
module insn_stream_decoder_test;
    localparam int LIMIT = 100000;

    typedef struct packed {
        logic [7:0]  op;
        logic [3:0]  mode;
        logic [1:0]  idx;
        logic [1:0]  size;
        logic [31:0] opnd;
        logic [2:0]  len;
        logic        inv;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_byte = 8'h00;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_opcode;
    logic [3:0]  out_mode;
    logic [1:0]  out_index;
    logic [1:0]  out_size;
    logic [31:0] out_operand;
    logic [2:0]  out_len;
    logic        out_invalid;

    always #4 clk = ~clk;

    insn_stream_decoder uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
        .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode),
        .out_mode(out_mode), .out_index(out_index), .out_size(out_size),
        .out_operand(out_operand), .out_len(out_len), .out_invalid(out_invalid)
    );

    int    checks = 0;
    int    failures = 0;
    int    cycle = 0;
    bit    timed_out = 1'b0;
    logic [7:0] tx_q[$];
    exp_t       exp_q[$];
    string      tag_q[$];
    bit    in_take = 1'b0;
    bit    hold_pend = 1'b0;
    exp_t  held;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, expv, cycle);
        end
    endtask

    // behavioural opcode table: {assigned, mode[3:0], idx[1:0]}
    function automatic logic [6:0] ref_class(input logic [7:0] op);
        if (op inside {8'h00, 8'h40, 8'h60, 8'h0A, 8'h2A, 8'h4A, 8'h6A, 8'h8A, 8'h9A,
                       8'hAA, 8'hBA, 8'hCA, 8'hEA} || op[3:0] == 4'h8)
            return {1'b1, 4'b0000, 2'b00};
        if (op[3:0] == 4'h0 && op[4]) return {1'b1, 4'b0001, 2'b00};
        if (op inside {8'hA0, 8'hC0, 8'hE0, 8'hA2, 8'h09, 8'h29, 8'h49, 8'h69, 8'hA9, 8'hC9, 8'hE9})
            return {1'b1, 4'b0010, 2'b00};
        if (op inside {8'h01, 8'h41, 8'h61, 8'h81, 8'hA1, 8'hC1, 8'hE1}) return {1'b1, 4'b0100, 2'b01};
        if (op[3:0] == 4'h1) return {1'b1, 4'b0100, 2'b10};
        if (op == 8'h6C) return {1'b1, 4'b0100, 2'b00};
        if (op inside {8'h19, 8'h39, 8'h59, 8'h79, 8'h99, 8'hB9, 8'hD9, 8'hF9, 8'hBE})
            return {1'b1, 4'b1000, 2'b10};
        if (op inside {8'h1D, 8'h3D, 8'h5D, 8'h7D, 8'h9D, 8'hBD, 8'hDD, 8'hFD,
                       8'h1E, 8'h3E, 8'h5E, 8'h7E, 8'hDE, 8'hFE, 8'hBC})
            return {1'b1, 4'b1000, 2'b01};
        if (op inside {8'h20, 8'h2C, 8'h4C, 8'h8C, 8'hAC, 8'hCC, 8'hEC,
                       8'h0D, 8'h2D, 8'h4D, 8'h6D, 8'h8D, 8'hAD, 8'hCD, 8'hED,
                       8'h0E, 8'h2E, 8'h4E, 8'h6E, 8'h8E, 8'hAE, 8'hCE, 8'hEE})
            return {1'b1, 4'b1000, 2'b00};
        return 7'b0;
    endfunction

    task automatic emit(input logic [7:0] op, input logic [7:0] attr, input logic [31:0] val);
        logic [6:0] c;
        exp_t e;
        string tag;
        int n;
        c = ref_class(op);
        e = '0;
        e.op = op;
        tx_q.push_back(op);
        if (!c[6]) begin
            e.inv = 1'b1; e.len = 3'd1; tag = "R6";
        end else begin
            e.mode = c[5:2];
            e.idx  = c[1:0];
            if (e.mode == 4'b0000) begin
                e.len = 3'd1; tag = "R1";
            end else if (e.mode == 4'b0001) begin
                tx_q.push_back(val[7:0]);
                tx_q.push_back(val[15:8]);
                e.opnd = {{16{val[15]}}, val[15:0]};
                e.len = 3'd3; tag = "R3";
            end else begin
                tx_q.push_back(attr);
                e.size = attr[1:0];
                if (e.mode == 4'b0010) begin
                    if (attr[1:0] == 2'd3) begin
                        e.inv = 1'b1; e.len = 3'd2; tag = "R5";
                    end else begin
                        n = 1 << attr[1:0];
                        for (int i = 0; i < n; i++) begin
                            tx_q.push_back(val[8*i +: 8]);
                            e.opnd[8*i +: 8] = val[8*i +: 8];
                        end
                        e.len = 3'(2 + n); tag = "R4";
                    end
                end else begin
                    for (int i = 0; i < 4; i++) tx_q.push_back(val[8*i +: 8]);
                    e.opnd = val; e.len = 3'd6; tag = "R7";
                end
            end
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic compare();
        exp_t e;
        string t;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R8 unexpected record", {56'h0, out_opcode}, 64'h0);
            return;
        end
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(out_opcode == e.op, {t, " opcode"}, {56'h0, out_opcode}, {56'h0, e.op});
        chk(out_mode == e.mode && out_index == e.idx, "R2 mode/index",
            {58'h0, out_mode, out_index}, {58'h0, e.mode, e.idx});
        chk(out_size == e.size, {t, " size"}, {62'h0, out_size}, {62'h0, e.size});
        chk(out_operand == e.opnd, {t, " operand"}, {32'h0, out_operand}, {32'h0, e.opnd});
        chk(out_len == e.len, {t, " length"}, {61'h0, out_len}, {61'h0, e.len});
        chk(out_invalid == e.inv, {t, " invalid"}, {63'h0, out_invalid}, {63'h0, e.inv});
    endtask

    task automatic step();
        @(negedge clk);
        cycle++;
        if (in_take) void'(tx_q.pop_front());
        out_ready = ($urandom_range(0, 3) != 0);
        chk(in_ready == !out_valid, "R8 input stall", {63'h0, in_ready}, {63'h0, !out_valid});
        if (hold_pend) begin
            chk(out_valid && out_opcode == held.op && out_operand == held.opnd && out_len == held.len
                && out_mode == held.mode && out_invalid == held.inv, "R8 hold",
                {out_valid, 23'h0, out_opcode, out_operand}, {1'b1, 23'h0, held.op, held.opnd});
        end
        if (out_valid && out_ready) compare();
        hold_pend = out_valid && !out_ready;
        held = '{op: out_opcode, mode: out_mode, idx: out_index, size: out_size,
                 opnd: out_operand, len: out_len, inv: out_invalid};
        if (!rst && tx_q.size() > 0 && $urandom_range(0, 4) != 0) begin
            in_valid = 1'b1;
            in_byte  = tx_q[0];
        end else begin
            in_valid = 1'b0;
        end
        in_take = in_valid && in_ready;
    endtask

    task automatic drain();
        while ((tx_q.size() > 0 || exp_q.size() > 0 || in_take || out_valid) && !timed_out) begin
            step();
            if (cycle > LIMIT) begin
                timed_out = 1'b1;
                chk(1'b0, "watchdog", 64'(cycle), 64'(LIMIT));
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: idle after reset
        chk(!out_valid && in_ready, "R9 reset state", {62'h0, out_valid, in_ready}, 64'h1);

        // directed cases
        emit(8'hEA, 8'h00, 32'h0);            // R1 implied
        emit(8'hD0, 8'h00, 32'h0000FF80);     // R3 negative offset
        emit(8'h10, 8'h00, 32'h00001234);     // R3 positive offset
        emit(8'hA9, 8'h00, 32'hA1B2C3D4);     // R4 1-byte literal
        emit(8'hA9, 8'hF1, 32'hA1B2C3D4);     // R4 2-byte literal
        emit(8'hA9, 8'h02, 32'hA1B2C3D4);     // R4 4-byte literal
        emit(8'h09, 8'h07, 32'h0);            // R5 bad size, next byte is opcode
        emit(8'hE8, 8'h00, 32'h0);
        emit(8'h02, 8'h00, 32'h0);            // R6 unassigned
        emit(8'h89, 8'h00, 32'h0);
        emit(8'h9E, 8'h00, 32'h0);
        emit(8'hAD, 8'h01, 32'hDEADBEEF);     // R7 absolute
        emit(8'h6C, 8'h02, 32'h80000001);     // R7 indirect
        emit(8'hB1, 8'h00, 32'h01020304);     // R7 indirect,Y
        drain();

        // R2 sweep across every opcode value
        for (int op = 0; op < 256; op++) begin
            logic [7:0] o;
            o = 8'(op);
            emit(o, {6'h15, o[2:1]}, {o, ~o, o ^ 8'h5A, 8'hC3});
        end
        drain();

        // R9: reset in the middle of an absolute instruction
        tx_q.push_back(8'hAD);
        tx_q.push_back(8'h11);
        tx_q.push_back(8'h22);
        while ((tx_q.size() > 0 || in_take) && !timed_out) begin
            step();
            if (cycle > LIMIT) begin
                timed_out = 1'b1;
                chk(1'b0, "watchdog", 64'(cycle), 64'(LIMIT));
            end
        end
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
        hold_pend = 1'b0;
        chk(!out_valid && in_ready, "R9 reset mid-instruction", {62'h0, out_valid, in_ready}, 64'h1);
        emit(8'hE8, 8'h00, 32'h0);
        emit(8'hA9, 8'h01, 32'h0000BEEF);
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule